// File: doc/BRIEF.md
# SMBus Protocol Transaction Sequencer

This block takes one SMBus request (protocol code, address byte, command byte and two data bytes), latches it, and walks through the byte-level commands that a lower bus master needs to carry it out: start with an address and direction, send a byte, receive a byte, refuse the last byte with a NACK, and stop. Each command is a one-cycle pulse on the command port. The sequencer then waits for exactly one response, which is either an acknowledge or an error.

Bytes read from the target are written back into the data0 and data1 registers. A sticky done flag reports success and a sticky device-error flag reports failure. For the two block protocols, the sequencer only performs the opening part of the transfer. It then raises a byte-done flag and a one-cycle handoff pulse, and leaves the bus open for a separate block buffer unit to continue the transfer.

While the device-error flag is set, no new transaction starts. The I2C-style block read always opens with a write-addressed start and sends data1 as the register offset, whatever the direction bit says.

Top module: `smbus_seq`

## Requirements
- R1: Protocol codes are 0 quick, 1 byte, 2 byte-data, 3 word-data, 5 block data and 6 I2C block read. Codes 4 (process call) and 7 set the device-error flag. They issue no bus command and leave data0 and data1 unchanged.
- R2: Command op encoding is 0 start, 1 send, 2 receive, 3 NACK and 4 stop.
  - A start carries address bits 7:1 in byte bits 7:1 and the direction in bit 0 (1 = read).
  - The other commands carry their byte value, or 0 when they have none.
  - A quick command is a start with the request's own direction bit, followed by a stop.
- R3: When a start request arrives while the device-error flag is set, no command is issued, the data registers are not reloaded, and device-error stays set.
- R4: A byte write is start-write, send command byte, stop. A byte read is start-read, receive into data0, NACK, stop.
- R5: A byte-data write is start-write, send command, send data0, stop. A byte-data read is start-write, send command, start-read, receive into data0, NACK, stop.
- R6: A word write is start-write, send command, send data0 (low byte), send data1 (high byte), stop. A word read is start-write, send command, start-read, receive data0, receive data1, NACK, stop.
- R7: An I2C block read is start-write, send data1, start-read, receive into the block byte output, then handoff. This holds whatever the request's direction bit is.
- R8: A block-data read is start-write, send command, start-read, receive the count into data0, then handoff. A block-data write is start-write, send command, send data0 (count), then handoff. Handoff sets byte-done and pulses handoff_o for one cycle, with no stop.
- R9: A successful non-block transfer sets the done flag. An error response on any command, including the stop, sets device-error instead and does not set done.
- R10: After an error response to a command other than stop, the next command is a stop. A response byte to a failed receive is not stored.
- R11: Only one transaction runs at a time. ready_o is low from the accepted start until the end, and a start while not ready is ignored.
- R12: flag_clr_i bit 0 clears done, bit 1 clears device-error and bit 2 clears byte-done. A set in the same cycle wins.
- R13: bus_cmd_valid_o is a single-cycle pulse, and no new command is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a transaction |
| proto_i | input | 3 | Protocol code |
| addr_i | input | 8 | Target address in bits 7:1, read flag in bit 0 |
| cmd_i | input | 8 | Command byte |
| data0_i | input | 8 | Data byte 0 (low byte / count) |
| data1_i | input | 8 | Data byte 1 (high byte / offset) |
| flag_clr_i | input | 3 | Clear strobes for done, device-error and byte-done |
| ready_o | output | 1 | Sequencer idle |
| data0_o | output | 8 | Data register 0 |
| data1_o | output | 8 | Data register 1 |
| blk_byte_o | output | 8 | First byte of an I2C block read |
| done_o | output | 1 | Success flag |
| dev_err_o | output | 1 | Device-error flag |
| byte_done_o | output | 1 | Byte-done flag set at handoff |
| handoff_o | output | 1 | One-cycle pulse passing a block transfer on |
| bus_cmd_valid_o | output | 1 | Command pulse to the bus master |
| bus_cmd_op_o | output | 3 | Command op |
| bus_cmd_byte_o | output | 8 | Command byte |
| bus_rsp_valid_i | input | 1 | Response from the bus master |
| bus_rsp_err_i | input | 1 | Response is an error (NACK or bus fault) |
| bus_rsp_data_i | input | 8 | Received byte for receive commands |

## Verification
The assertions take for granted that the bus master answers every command pulse exactly once, at least one cycle later, and never raises a response while the sequencer is idle. The bench responder meets this assumption. It waits for each command pulse, lets a random delay of zero to two cycles pass, and then drives a single response. That response carries an error only on the command index chosen for error injection. The responder never answers after a handoff, because no command is outstanding at that point.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;
  localparam logic [2:0] PR_IBLK  = 3'd6;

  typedef enum logic [2:0] {
    BOP_START = 3'd0,
    BOP_SEND  = 3'd1,
    BOP_RECV  = 3'd2,
    BOP_NACK  = 3'd3,
    BOP_STOP  = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    MK_START_W, MK_START_R, MK_SEND, MK_RECV, MK_NACK, MK_STOP, MK_HAND
  } step_kind_e;

  typedef enum logic [1:0] {SRC_CMD, SRC_D0, SRC_D1} src_e;
  typedef enum logic [1:0] {DST_NONE, DST_D0, DST_D1, DST_BLK} dst_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;

  typedef struct packed {
    step_kind_e kind;
    src_e       src;
    dst_e       dst;
  } step_t;

  function automatic logic proto_supported(input logic [2:0] p);
    return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
           (p == PR_WORD) || (p == PR_BLOCK) || (p == PR_IBLK);
  endfunction

  function automatic step_t mk_step(input step_kind_e k, input src_e s, input dst_e d);
    step_t t;
    t.kind = k;
    t.src  = s;
    t.dst  = d;
    return t;
  endfunction

endpackage

// File: rtl/smbseq_plan.sv
module smbseq_plan
  import smbseq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [2:0]        proto_i,
  input  logic              rd_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);

  step_t sw, sr, stp, hnd, nack;

  always_comb begin
    sw   = mk_step(MK_START_W, SRC_CMD, DST_NONE);
    sr   = mk_step(MK_START_R, SRC_CMD, DST_NONE);
    stp  = mk_step(MK_STOP,    SRC_CMD, DST_NONE);
    hnd  = mk_step(MK_HAND,    SRC_CMD, DST_NONE);
    nack = mk_step(MK_NACK,    SRC_CMD, DST_NONE);
    step_o = stp;
    case (proto_i)
      PR_QUICK: begin
        if (idx_i == '0) step_o = rd_i ? sr : sw;
      end
      PR_BYTE: begin
        if (rd_i) begin
          case (int'(idx_i))
            0: step_o = sr;
            1: step_o = mk_step(MK_RECV, SRC_CMD, DST_D0);
            2: step_o = nack;
            default: step_o = stp;
          endcase
        end else begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            default: step_o = stp;
          endcase
        end
      end
      PR_BDATA: begin
        if (rd_i) begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = sr;
            3: step_o = mk_step(MK_RECV, SRC_CMD, DST_D0);
            4: step_o = nack;
            default: step_o = stp;
          endcase
        end else begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = mk_step(MK_SEND, SRC_D0, DST_NONE);
            default: step_o = stp;
          endcase
        end
      end
      PR_WORD: begin
        if (rd_i) begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = sr;
            3: step_o = mk_step(MK_RECV, SRC_CMD, DST_D0);
            4: step_o = mk_step(MK_RECV, SRC_CMD, DST_D1);
            5: step_o = nack;
            default: step_o = stp;
          endcase
        end else begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = mk_step(MK_SEND, SRC_D0, DST_NONE);
            3: step_o = mk_step(MK_SEND, SRC_D1, DST_NONE);
            default: step_o = stp;
          endcase
        end
      end
      PR_BLOCK: begin
        if (rd_i) begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = sr;
            3: step_o = mk_step(MK_RECV, SRC_CMD, DST_D0);
            default: step_o = hnd;
          endcase
        end else begin
          case (int'(idx_i))
            0: step_o = sw;
            1: step_o = mk_step(MK_SEND, SRC_CMD, DST_NONE);
            2: step_o = mk_step(MK_SEND, SRC_D0, DST_NONE);
            default: step_o = hnd;
          endcase
        end
      end
      PR_IBLK: begin
        case (int'(idx_i))
          0: step_o = sw;
          1: step_o = mk_step(MK_SEND, SRC_D1, DST_NONE);
          2: step_o = sr;
          3: step_o = mk_step(MK_RECV, SRC_CMD, DST_BLK);
          default: step_o = hnd;
        endcase
      end
      default: step_o = stp;
    endcase
  end

endmodule

// File: rtl/smbseq_regs.sv
module smbseq_regs
  import smbseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [2:0]    proto_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] d0_i,
  input  logic [DW-1:0] d1_i,
  input  logic          store_i,
  input  dst_e          dst_i,
  input  logic [DW-1:0] rx_i,
  input  logic          set_done_i,
  input  logic          set_err_i,
  input  logic          set_bdone_i,
  input  logic [2:0]    clr_i,
  output logic [2:0]    proto_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] d0_q,
  output logic [DW-1:0] d1_q,
  output logic [DW-1:0] blk_q,
  output logic          done_o,
  output logic          dev_err_o,
  output logic          bdone_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      proto_q <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      blk_q   <= '0;
    end else if (load_i) begin
      proto_q <= proto_i;
      addr_q  <= addr_i;
      cmd_q   <= cmd_i;
      d0_q    <= d0_i;
      d1_q    <= d1_i;
    end else if (store_i) begin
      case (dst_i)
        DST_D0:  d0_q  <= rx_i;
        DST_D1:  d1_q  <= rx_i;
        DST_BLK: blk_q <= rx_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      dev_err_o <= 1'b0;
      bdone_o   <= 1'b0;
    end else begin
      if (set_done_i)       done_o <= 1'b1;
      else if (clr_i[0])    done_o <= 1'b0;
      if (set_err_i)        dev_err_o <= 1'b1;
      else if (clr_i[1])    dev_err_o <= 1'b0;
      if (set_bdone_i)      bdone_o <= 1'b1;
      else if (clr_i[2])    bdone_o <= 1'b0;
    end
  end

  // R9
  excl_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> !$rose(dev_err_o));

  // R12
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i[0] && !set_done_i) |=> !done_o);

endmodule

// File: rtl/smbseq_ctrl.sv
module smbseq_ctrl
  import smbseq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        proto_i,
  input  logic              dev_err_i,
  input  step_kind_e        kind_i,
  input  src_e              src_i,
  input  logic [DW-2:0]     tgt_i,
  input  logic [DW-1:0]     cmd_q_i,
  input  logic [DW-1:0]     d0_q_i,
  input  logic [DW-1:0]     d1_q_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic [STEP_W-1:0] idx_o,
  output logic              ready_o,
  output logic              load_o,
  output logic              store_o,
  output logic              set_done_o,
  output logic              set_err_o,
  output logic              set_bdone_o,
  output logic              handoff_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [DW-1:0]     cmd_byte_o
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic              abort_q, abort_d;
  logic              issue, hand_d;
  step_kind_e        cur_kind;
  bus_op_e           op_d;
  logic [DW-1:0]     byte_d;

  assign cur_kind = abort_q ? MK_STOP : kind_i;
  assign idx_o    = idx_q;
  assign ready_o  = (state_q == ST_IDLE);

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    abort_d     = abort_q;
    load_o      = 1'b0;
    store_o     = 1'b0;
    set_done_o  = 1'b0;
    set_err_o   = 1'b0;
    set_bdone_o = 1'b0;
    issue       = 1'b0;
    hand_d      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && !dev_err_i) begin
          if (proto_supported(proto_i)) begin
            load_o  = 1'b1;
            idx_d   = '0;
            abort_d = 1'b0;
            state_d = ST_ISSUE;
          end else begin
            set_err_o = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (cur_kind == MK_HAND) begin
          set_bdone_o = 1'b1;
          hand_d      = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          issue   = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          if (cur_kind == MK_STOP) begin
            if (abort_q || rsp_err_i) set_err_o = 1'b1;
            else                      set_done_o = 1'b1;
            state_d = ST_IDLE;
          end else if (rsp_err_i) begin
            abort_d = 1'b1;
            state_d = ST_ISSUE;
          end else begin
            store_o = (cur_kind == MK_RECV);
            idx_d   = idx_q + STEP_W'(1);
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_d   = BOP_STOP;
    byte_d = '0;
    case (cur_kind)
      MK_START_W: begin op_d = BOP_START; byte_d = {tgt_i, 1'b0}; end
      MK_START_R: begin op_d = BOP_START; byte_d = {tgt_i, 1'b1}; end
      MK_SEND: begin
        op_d = BOP_SEND;
        case (src_i)
          SRC_D0:  byte_d = d0_q_i;
          SRC_D1:  byte_d = d1_q_i;
          default: byte_d = cmd_q_i;
        endcase
      end
      MK_RECV: op_d = BOP_RECV;
      MK_NACK: op_d = BOP_NACK;
      default: op_d = BOP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      abort_q     <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_byte_o  <= '0;
      handoff_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      abort_q     <= abort_d;
      cmd_valid_o <= issue;
      handoff_o   <= hand_d;
      if (issue) begin
        cmd_op_o   <= op_d;
        cmd_byte_o <= byte_d;
      end
    end
  end

  // R13
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  // R11
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> !ready_o);

  // R3
  blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_i && dev_err_i) |=> (ready_o && !cmd_valid_o));

  // R13
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i |-> !ready_o);

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbseq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STEP_W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    proto_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] data0_i,
  input  logic [DW-1:0] data1_i,
  input  logic [2:0]    flag_clr_i,
  output logic          ready_o,
  output logic [DW-1:0] data0_o,
  output logic [DW-1:0] data1_o,
  output logic [DW-1:0] blk_byte_o,
  output logic          done_o,
  output logic          dev_err_o,
  output logic          byte_done_o,
  output logic          handoff_o,
  output logic          bus_cmd_valid_o,
  output logic [2:0]    bus_cmd_op_o,
  output logic [DW-1:0] bus_cmd_byte_o,
  input  logic          bus_rsp_valid_i,
  input  logic          bus_rsp_err_i,
  input  logic [DW-1:0] bus_rsp_data_i
);

  logic [2:0]        proto_q;
  logic [DW-1:0]     addr_q, cmd_q;
  logic [STEP_W-1:0] idx;
  step_t             step;
  logic              load, store, set_done, set_err, set_bdone;

  smbseq_plan #(.STEP_W(STEP_W)) plan_i (
    .proto_i (proto_q),
    .rd_i    (addr_q[0]),
    .idx_i   (idx),
    .step_o  (step)
  );

  smbseq_ctrl #(.DW(DW), .STEP_W(STEP_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .proto_i     (proto_i),
    .dev_err_i   (dev_err_o),
    .kind_i      (step.kind),
    .src_i       (step.src),
    .tgt_i       (addr_q[DW-1:1]),
    .cmd_q_i     (cmd_q),
    .d0_q_i      (data0_o),
    .d1_q_i      (data1_o),
    .rsp_valid_i (bus_rsp_valid_i),
    .rsp_err_i   (bus_rsp_err_i),
    .idx_o       (idx),
    .ready_o     (ready_o),
    .load_o      (load),
    .store_o     (store),
    .set_done_o  (set_done),
    .set_err_o   (set_err),
    .set_bdone_o (set_bdone),
    .handoff_o   (handoff_o),
    .cmd_valid_o (bus_cmd_valid_o),
    .cmd_op_o    (bus_cmd_op_o),
    .cmd_byte_o  (bus_cmd_byte_o)
  );

  smbseq_regs #(.DW(DW)) regs_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .proto_i     (proto_i),
    .addr_i      (addr_i),
    .cmd_i       (cmd_i),
    .d0_i        (data0_i),
    .d1_i        (data1_i),
    .store_i     (store),
    .dst_i       (step.dst),
    .rx_i        (bus_rsp_data_i),
    .set_done_i  (set_done),
    .set_err_i   (set_err),
    .set_bdone_i (set_bdone),
    .clr_i       (flag_clr_i),
    .proto_q     (proto_q),
    .addr_q      (addr_q),
    .cmd_q       (cmd_q),
    .d0_q        (data0_o),
    .d1_q        (data1_o),
    .blk_q       (blk_byte_o),
    .done_o      (done_o),
    .dev_err_o   (dev_err_o),
    .bdone_o     (byte_done_o)
  );

endmodule

// File: tb/smbus_seq_tb_top.sv
`timescale 1ns/1ps
module smbus_seq_tb_top;

  localparam logic [2:0] OP_START = 3'd0, OP_SEND = 3'd1, OP_RECV = 3'd2,
                         OP_NACK = 3'd3, OP_STOP = 3'd4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, start, rsp_valid, rsp_err;
  logic [2:0] proto, clr;
  logic [7:0] addr, cmd, d0, d1, rsp_data;
  logic       ready, done, dev_err, bdone, handoff, cvalid;
  logic [7:0] q0, q1, qblk, cbyte;
  logic [2:0] cop;

  smbus_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start), .proto_i(proto), .addr_i(addr),
    .cmd_i(cmd), .data0_i(d0), .data1_i(d1), .flag_clr_i(clr),
    .ready_o(ready), .data0_o(q0), .data1_o(q1), .blk_byte_o(qblk),
    .done_o(done), .dev_err_o(dev_err), .byte_done_o(bdone), .handoff_o(handoff),
    .bus_cmd_valid_o(cvalid), .bus_cmd_op_o(cop), .bus_cmd_byte_o(cbyte),
    .bus_rsp_valid_i(rsp_valid), .bus_rsp_err_i(rsp_err), .bus_rsp_data_i(rsp_data)
  );

  int total = 0, fails = 0;
  bit finished = 0;

  logic [2:0] log_op[32];
  logic [7:0] log_byte[32];
  int log_n, rx_i, err_at, hand_cnt, dbl_valid;
  logic [7:0] rx_pool[8];
  logic prev_valid;

  logic [2:0] ex_op[16];
  logic [7:0] ex_byte[16];
  int ex_n;
  logic [7:0] e_d0, e_d1, e_blk;
  logic e_done, e_err, e_bd;
  int e_hand;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // responder and monitor
  initial begin
    rsp_valid = 0; rsp_err = 0; rsp_data = 0; log_n = 0; rx_i = 0;
    forever begin
      @(negedge clk);
      if (cvalid) begin
        int k;
        k = log_n;
        if (k < 32) begin log_op[k] = cop; log_byte[k] = cbyte; end
        log_n++;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rsp_valid = 1;
        rsp_err   = (k == err_at);
        rsp_data  = 8'h00;
        if (cop == OP_RECV) begin rsp_data = rx_pool[rx_i % 8]; rx_i++; end
        @(negedge clk);
        rsp_valid = 0; rsp_err = 0;
      end
    end
  end

  initial begin
    hand_cnt = 0; dbl_valid = 0; prev_valid = 0;
    forever begin
      @(negedge clk);
      if (handoff) hand_cnt++;
      if (cvalid && prev_valid) dbl_valid++;
      prev_valid = cvalid;
    end
  end

  // expected model
  logic [2:0] fl_op[16];
  logic [7:0] fl_byte[16];
  int fl_dst[16];
  int fl_n;

  task automatic fadd(input logic [2:0] op, input logic [7:0] b, input int dst);
    fl_op[fl_n] = op; fl_byte[fl_n] = b; fl_dst[fl_n] = dst; fl_n++;
  endtask

  task automatic eadd(input logic [2:0] op, input logic [7:0] b);
    ex_op[ex_n] = op; ex_byte[ex_n] = b; ex_n++;
  endtask

  task automatic model(input logic [2:0] p, input logic [7:0] a, input logic [7:0] c,
                       input logic [7:0] x0, input logic [7:0] x1, input int eat);
    logic [7:0] sw, sr;
    bit rd, hand, hit;
    int rxk;
    sw = {a[7:1], 1'b0}; sr = {a[7:1], 1'b1}; rd = a[0];
    ex_n = 0; fl_n = 0; hand = 0; hit = 0; rxk = 0;
    if (e_err) return;
    if (!(p <= 3 || p == 5 || p == 6)) begin e_err = 1; return; end
    e_d0 = x0; e_d1 = x1;
    case (p)
      0: begin fadd(OP_START, a, 0); fadd(OP_STOP, 0, 0); end
      1: if (rd) begin fadd(OP_START, sr, 0); fadd(OP_RECV, 0, 1); fadd(OP_NACK, 0, 0); fadd(OP_STOP, 0, 0); end
         else begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_STOP, 0, 0); end
      2: if (rd) begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_START, sr, 0);
                       fadd(OP_RECV, 0, 1); fadd(OP_NACK, 0, 0); fadd(OP_STOP, 0, 0); end
         else begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_SEND, x0, 0); fadd(OP_STOP, 0, 0); end
      3: if (rd) begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_START, sr, 0);
                       fadd(OP_RECV, 0, 1); fadd(OP_RECV, 0, 2); fadd(OP_NACK, 0, 0); fadd(OP_STOP, 0, 0); end
         else begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_SEND, x0, 0);
                    fadd(OP_SEND, x1, 0); fadd(OP_STOP, 0, 0); end
      5: begin
           hand = 1;
           if (rd) begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_START, sr, 0); fadd(OP_RECV, 0, 1); end
           else begin fadd(OP_START, sw, 0); fadd(OP_SEND, c, 0); fadd(OP_SEND, x0, 0); end
         end
      default: begin
           hand = 1;
           fadd(OP_START, sw, 0); fadd(OP_SEND, x1, 0); fadd(OP_START, sr, 0); fadd(OP_RECV, 0, 3);
         end
    endcase
    for (int i = 0; i < fl_n; i++) begin
      eadd(fl_op[i], fl_byte[i]);
      if (i == eat) begin
        if (fl_op[i] != OP_STOP) eadd(OP_STOP, 0);
        e_err = 1; hit = 1;
        break;
      end
      if (fl_op[i] == OP_RECV) begin
        case (fl_dst[i])
          1: e_d0 = rx_pool[rxk];
          2: e_d1 = rx_pool[rxk];
          default: e_blk = rx_pool[rxk];
        endcase
        rxk++;
      end
    end
    if (!hit) begin
      if (hand) begin e_bd = 1; e_hand = 1; end
      else e_done = 1;
    end
  endtask

  function automatic string tag_of(input logic [2:0] p, input int eat);
    if (eat >= 0) return "R10";
    case (p)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      5: return "R8";
      6: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic clear_flags(input logic [2:0] bits);
    @(negedge clk); clr = bits; @(negedge clk); clr = 0;
    if (bits[0]) e_done = 0;
    if (bits[1]) e_err = 0;
    if (bits[2]) e_bd = 0;
  endtask

  task automatic run_txn(input logic [2:0] p, input logic [7:0] a, input logic [7:0] c,
                         input logic [7:0] x0, input logic [7:0] x1, input int eat,
                         input bit poke, input string tag);
    int t;
    bit seq_ok;
    @(negedge clk);
    proto = p; addr = a; cmd = c; d0 = x0; d1 = x1;
    err_at = eat; log_n = 0; rx_i = 0; hand_cnt = 0; e_hand = 0;
    for (int i = 0; i < 8; i++) rx_pool[i] = 8'($urandom);
    model(p, a, c, x0, x1, eat);
    start = 1; @(negedge clk); start = 0;
    if (poke) begin
      proto = 3'd0; addr = ~a; cmd = ~c; d0 = ~x0; d1 = ~x1;
      start = 1; @(negedge clk); start = 0;
    end
    t = 0;
    while (!ready && t < 500) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    seq_ok = (log_n == ex_n);
    for (int i = 0; i < ex_n && i < 32; i++)
      if (log_op[i] != ex_op[i] || log_byte[i] != ex_byte[i]) seq_ok = 0;
    chk(seq_ok, {tag, " command sequence (count)"}, log_n, ex_n);
    chk(q0 == e_d0 && q1 == e_d1, {tag, " data0/data1"}, {q1, q0}, {e_d1, e_d0});
    if (p == 3'd6) chk(qblk == e_blk, "R7 block byte", qblk, e_blk);
    chk({done, dev_err, bdone} == {e_done, e_err, e_bd}, "R9 flags done/err/bdone",
        {done, dev_err, bdone}, {e_done, e_err, e_bd});
    chk(hand_cnt == e_hand, "R8 handoff pulses", hand_cnt, e_hand);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; start = 0; proto = 0; addr = 0; cmd = 0; d0 = 0; d1 = 0; clr = 0; err_at = -1;
    e_d0 = 0; e_d1 = 0; e_blk = 0; e_done = 0; e_err = 0; e_bd = 0; e_hand = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready && !done && !dev_err && !bdone && !cvalid && !handoff, "R11 reset state",
        {ready, done, dev_err, bdone, cvalid}, 5'b10000);

    // R2 quick both directions
    run_txn(3'd0, 8'hA5, 8'h11, 8'h22, 8'h33, -1, 0, "R2");
    clear_flags(3'b111);
    run_txn(3'd0, 8'h5A, 8'h11, 8'h22, 8'h33, -1, 0, "R2");
    clear_flags(3'b111);
    // R4 / R5 / R6 directed
    run_txn(3'd1, 8'h91, 8'h3C, 8'h00, 8'h00, -1, 0, "R4");
    clear_flags(3'b111);
    run_txn(3'd2, 8'h90, 8'h3C, 8'hE7, 8'h00, -1, 0, "R5");
    clear_flags(3'b111);
    run_txn(3'd3, 8'h91, 8'h3C, 8'h12, 8'h34, -1, 0, "R6");
    clear_flags(3'b111);
    // R7 with read bit set and clear
    run_txn(3'd6, 8'h61, 8'h77, 8'h01, 8'h40, -1, 0, "R7");
    clear_flags(3'b111);
    run_txn(3'd6, 8'h60, 8'h77, 8'h01, 8'h41, -1, 0, "R7");
    clear_flags(3'b111);
    // R8 block read and write
    run_txn(3'd5, 8'h23, 8'h08, 8'h05, 8'h00, -1, 0, "R8");
    clear_flags(3'b111);
    run_txn(3'd5, 8'h22, 8'h08, 8'h05, 8'h00, -1, 0, "R8");
    clear_flags(3'b111);
    // R11 start while busy ignored
    run_txn(3'd3, 8'h41, 8'h0F, 8'hAA, 8'h55, -1, 1, "R11");
    // R12 partial clear: done only
    clear_flags(3'b001);
    chk(!done, "R12 done cleared", done, 0);
    // R10 error on the receive step, then R3 blocked start
    run_txn(3'd2, 8'h71, 8'h3C, 8'h99, 8'h88, 3, 0, "R10");
    run_txn(3'd0, 8'h70, 8'h01, 8'h02, 8'h03, -1, 0, "R3");
    clear_flags(3'b010);
    chk(!dev_err, "R12 dev_err cleared", dev_err, 0);
    // R9 error on stop
    run_txn(3'd1, 8'h30, 8'h44, 8'h00, 8'h00, 2, 0, "R9");
    clear_flags(3'b111);
    // R1 unsupported codes
    run_txn(3'd4, 8'h30, 8'h44, 8'h10, 8'h20, -1, 0, "R1");
    clear_flags(3'b111);
    run_txn(3'd7, 8'h31, 8'h44, 8'h10, 8'h20, -1, 0, "R1");
    clear_flags(3'b111);
    // R10 error on first start, block handoff aborted
    run_txn(3'd5, 8'h31, 8'h44, 8'h10, 8'h20, 0, 0, "R10");
    clear_flags(3'b111);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [2:0] p;
      int eat;
      p = 3'($urandom_range(0, 7));
      eat = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : -1;
      run_txn(p, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), eat, 0, tag_of(p, eat));
      clear_flags(3'b111);
    end

    chk(dbl_valid == 0, "R13 single-cycle command pulses", dbl_valid, 0);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule